// File: doc/BRIEF.md
# Vector Extension Prefix Decoder

This block sits at the front of a 64-bit-mode instruction decoder and watches the instruction byte stream one byte per cycle. It skips ordinary legacy prefixes. It recognises the four vector-extension lead bytes: C5h (short VEX), C4h (long VEX), 8Fh (XOP) and 62h (EVEX). It gathers the payload bytes that follow the lead byte and then takes the next byte as the opcode.

When the opcode byte is accepted, the block presents a normalised field set. The register-extension bits and the second-source specifier, which travel inverted, are complemented here. The short form's fixed map is supplied. The pp field is turned into the legacy prefix byte it stands for. The EVEX masking and broadcast bits are separated out. A fault flag reports encodings that must raise an invalid-opcode exception.

The upstream fetch logic marks the first byte of every instruction with `in_first`. After it has emitted an opcode, the block ignores bytes until the next marked byte arrives, because ModRM, SIB, displacement and immediate bytes belong to a later stage. A marked byte always restarts decoding, even in the middle of a prefix.

Top module: `vecpfx_decoder`

## Requirements
- R1: In prefix position, the bytes 26h, 2Eh, 36h, 3Eh, 64h, 65h, 67h, F0h, 66h, F2h, F3h and 40h–4Fh are consumed without output. Any other byte except C4h, C5h, 62h and 8Fh is the opcode. It is emitted with pfx_kind 0 and every vector field zero. op_valid is high for the one cycle after the opcode byte is accepted, and op_byte carries that byte. After reset, op_valid, pfx_kind and ud_fault are 0.
- R2: After C5h, one payload byte follows, with bit 7 = R, bits 6:3 = vvvv, bit 2 = L and bits 1:0 = pp. The block reports pfx_kind 1 and map_sel 1. ext_x, ext_b, ext_r2, w_bit and the vsrc extension bit are all 0.
- R3: After C4h, two payload bytes follow and pfx_kind is 2. After 8Fh, two payload bytes follow and pfx_kind is 3. The first payload byte is R(7) X(6) B(5) map(4:0). The second is W(7) vvvv(6:3) L(2) pp(1:0).
- R4: An 8Fh whose following byte has bits 4:0 below 8 is the legacy opcode 8Fh. It is emitted with pfx_kind 0 and op_byte 8Fh in the cycle after that following byte is accepted.
- R5: After 62h, three payload bytes follow and pfx_kind is 4. Byte 1 is R(7) X(6) B(5) R'(4) B'(3) map(2:0), and map_sel is {00, map}. Byte 2 is W(7) vvvv(6:3) U(2) pp(1:0). Byte 3 is z(7) LL(6:5) b(4) v'(3) aaa(2:0). The block outputs mask_z = z, evex_b = b, mask_aaa = aaa and vlen = LL.
- R6: R, X, B, R', v' and vvvv are stored inverted. ext_r, ext_x, ext_b, ext_r2 and vvvv present them complemented.
- R7: simd_pfx is 00h, 66h, F3h or F2h for pp = 00, 01, 10 or 11.
- R8: reg_hi = {ext_r2, ext_r} and vsrc = {complemented v', vvvv}. Outside EVEX, the upper bit of each is 0.
- R9: xop_imm is 1 only for XOP with map 08h or 0Ah.
- R10: ud_fault is set for a vector prefix when 66h, F2h, F3h or any 40h–4Fh byte came earlier in the same instruction.
- R11: ud_fault is also set for an unsupported map or a reserved length. The unsupported maps are: long VEX map outside 1–3, XOP map outside 08h–0Ah, and EVEX map 0 or 7. The reserved length is EVEX LL = 11 with b = 0.
- R12: Bytes after an emitted opcode produce no output until a byte with in_first arrives. A byte with in_first restarts decoding from prefix position.
- R13: For VEX and XOP, vlen = {0, L}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_byte carries a stream byte this cycle |
| in_first | input | 1 | The byte is the first of an instruction |
| in_byte | input | 8 | Instruction stream byte |
| op_valid | output | 1 | One-cycle pulse: opcode and fields are ready |
| op_byte | output | 8 | Opcode byte |
| pfx_kind | output | 3 | 0 none, 1 short VEX, 2 long VEX, 3 XOP, 4 EVEX |
| ext_r | output | 1 | ModRM reg extension |
| ext_x | output | 1 | SIB index extension |
| ext_b | output | 1 | r/m or base extension |
| ext_r2 | output | 1 | Second ModRM reg extension (EVEX) |
| w_bit | output | 1 | W bit |
| vvvv | output | 4 | Second source register, true polarity |
| vsrc | output | 5 | Five-bit second source index |
| reg_hi | output | 2 | Upper two bits of the five-bit reg index |
| map_sel | output | 5 | Opcode map |
| vlen | output | 2 | Vector length, or rounding control when evex_b is 1 |
| simd_pfx | output | 8 | Implied legacy prefix byte |
| mask_z | output | 1 | Zeroing-masking bit |
| evex_b | output | 1 | Broadcast / rounding bit |
| mask_aaa | output | 3 | Mask register select |
| xop_imm | output | 1 | An immediate byte follows this XOP opcode |
| ud_fault | output | 1 | Invalid-opcode fault |

## Verification
The fields are held in registers that are written only when the opcode is accepted. A mis-sequenced byte counter therefore shows up the next cycle as a missing or doubled op_valid pulse, or as an op_byte taken from a payload position. A wrong payload register or a polarity slip appears on the field ports in that same cycle. The bench checks those ports against per-format models.

A stale legacy-prefix flag shows up only later, as ud_fault on the first vector-prefixed instruction after it. The bench therefore mixes clean and faulting prefix runs, and it directly tests restarts in the middle of a prefix.

// File: rtl/vecpfx_decoder.sv
module vecpfx_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_first,
  input  logic [7:0] in_byte,
  output logic       op_valid,
  output logic [7:0] op_byte,
  output logic [2:0] pfx_kind,
  output logic       ext_r,
  output logic       ext_x,
  output logic       ext_b,
  output logic       ext_r2,
  output logic       w_bit,
  output logic [3:0] vvvv,
  output logic [4:0] vsrc,
  output logic [1:0] reg_hi,
  output logic [4:0] map_sel,
  output logic [1:0] vlen,
  output logic [7:0] simd_pfx,
  output logic       mask_z,
  output logic       evex_b,
  output logic [2:0] mask_aaa,
  output logic       xop_imm,
  output logic       ud_fault
);
  localparam logic [2:0] K_NONE = 3'd0;
  localparam logic [2:0] K_VEX2 = 3'd1;
  localparam logic [2:0] K_VEX3 = 3'd2;
  localparam logic [2:0] K_XOP  = 3'd3;
  localparam logic [2:0] K_EVEX = 3'd4;

  typedef enum logic [2:0] {S_PFX, S_P1, S_P2, S_P3, S_OP, S_HOLD} st_t;

  st_t        st, st_e;
  logic [2:0] kind, o_kind;
  logic [7:0] p1, p2, p3, o_p1, o_p2, o_p3;
  logic       bad, o_bad;

  assign st_e = in_first ? S_PFX : st;
  wire bad_e   = in_first ? 1'b0 : bad;
  wire pfx_bad = (in_byte == 8'h66) || (in_byte == 8'hF2) || (in_byte == 8'hF3) || (in_byte[7:4] == 4'h4);
  wire pfx_ok  = in_byte inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h67, 8'hF0};
  wire lead    = in_byte inside {8'hC4, 8'hC5, 8'h62, 8'h8F};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PFX; kind <= K_NONE; bad <= 1'b0;
      p1 <= '0; p2 <= '0; p3 <= '0;
      op_valid <= 1'b0; op_byte <= '0; o_kind <= K_NONE;
      o_p1 <= '0; o_p2 <= '0; o_p3 <= '0; o_bad <= 1'b0;
    end else begin
      op_valid <= 1'b0;
      if (in_valid) begin
        case (st_e)
          S_PFX: begin
            bad <= bad_e | pfx_bad;
            if (pfx_bad || pfx_ok) begin
              st <= S_PFX;
            end else if (lead) begin
              kind <= (in_byte == 8'hC5) ? K_VEX2 :
                      (in_byte == 8'hC4) ? K_VEX3 :
                      (in_byte == 8'h8F) ? K_XOP  : K_EVEX;
              st <= S_P1;
            end else begin
              op_valid <= 1'b1; op_byte <= in_byte;
              o_kind <= K_NONE; o_bad <= 1'b0;
              st <= S_HOLD;
            end
          end
          S_P1: begin
            p1 <= in_byte;
            if (kind == K_XOP && in_byte[4:3] == 2'b00) begin
              op_valid <= 1'b1; op_byte <= 8'h8F;
              o_kind <= K_NONE; o_bad <= 1'b0;
              st <= S_HOLD;
            end else begin
              st <= (kind == K_VEX2) ? S_OP : S_P2;
            end
          end
          S_P2: begin
            p2 <= in_byte;
            st <= (kind == K_EVEX) ? S_P3 : S_OP;
          end
          S_P3: begin
            p3 <= in_byte;
            st <= S_OP;
          end
          S_OP: begin
            op_valid <= 1'b1; op_byte <= in_byte;
            o_kind <= kind; o_bad <= bad;
            o_p1 <= p1; o_p2 <= p2; o_p3 <= p3;
            st <= S_HOLD;
          end
          default: st <= S_HOLD;
        endcase
      end
    end
  end

  wire       vec  = (o_kind != K_NONE);
  wire       ev   = (o_kind == K_EVEX);
  wire       v2   = (o_kind == K_VEX2);
  wire       wide = vec & ~v2;
  wire [7:0] wb   = v2 ? o_p1 : o_p2;
  wire [1:0] pp   = vec ? wb[1:0] : 2'b00;

  assign pfx_kind = o_kind;
  assign ext_r    = vec  & ~o_p1[7];
  assign ext_x    = wide & ~o_p1[6];
  assign ext_b    = wide & ~o_p1[5];
  assign ext_r2   = ev   & ~o_p1[4];
  assign w_bit    = wide & wb[7];
  assign vvvv     = vec ? ~wb[6:3] : 4'h0;
  assign vsrc     = {ev & ~o_p3[3], vvvv};
  assign reg_hi   = {ext_r2, ext_r};
  assign map_sel  = v2 ? 5'd1 : ev ? {2'b00, o_p1[2:0]} : wide ? o_p1[4:0] : 5'd0;
  assign vlen     = ev ? o_p3[6:5] : vec ? {1'b0, wb[2]} : 2'b00;
  assign mask_z   = ev & o_p3[7];
  assign evex_b   = ev & o_p3[4];
  assign mask_aaa = ev ? o_p3[2:0] : 3'd0;
  assign xop_imm  = (o_kind == K_XOP) && (map_sel == 5'd8 || map_sel == 5'd10);

  always_comb begin
    case (pp)
      2'b01:   simd_pfx = 8'h66;
      2'b10:   simd_pfx = 8'hF3;
      2'b11:   simd_pfx = 8'hF2;
      default: simd_pfx = 8'h00;
    endcase
  end

  logic map_ok;
  always_comb begin
    case (o_kind)
      K_VEX3:  map_ok = (map_sel >= 5'd1) && (map_sel <= 5'd3);
      K_XOP:   map_ok = (map_sel >= 5'd8) && (map_sel <= 5'd10);
      K_EVEX:  map_ok = (o_p1[2:0] != 3'd0) && (o_p1[2:0] != 3'd7);
      default: map_ok = 1'b1;
    endcase
  end

  assign ud_fault = vec & (o_bad | ~map_ok | (ev & (vlen == 2'b11) & ~evex_b));
endmodule

module vecpfx_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       op_valid,
  input logic [2:0] pfx_kind,
  input logic [4:0] map_sel,
  input logic       ext_x,
  input logic       ext_b,
  input logic       w_bit,
  input logic [1:0] vlen,
  input logic       mask_z,
  input logic       evex_b,
  input logic [2:0] mask_aaa,
  input logic       xop_imm,
  input logic       ud_fault
);
  // R12
  opcode_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(in_valid));
  // R2
  short_form_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && pfx_kind == 3'd1) |-> (map_sel == 5'd1 && !ext_x && !ext_b && !w_bit));
  // R9
  xop_imm_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xop_imm |-> (pfx_kind == 3'd3));
  // R5
  mask_only_evex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_kind != 3'd4) |-> (mask_aaa == 3'd0 && !mask_z && !evex_b));
  // R11
  reserved_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && pfx_kind == 3'd4 && vlen == 2'b11 && !evex_b) |-> ud_fault);
  // R10
  plain_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && pfx_kind == 3'd0) |-> !ud_fault);
endmodule

bind vecpfx_decoder vecpfx_decoder_chk u_chk (.*);

// File: tb/vecpfx_decoder_tb.sv
module vecpfx_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic op_valid, ext_r, ext_x, ext_b, ext_r2, w_bit, mask_z, evex_b, xop_imm, ud_fault;
  logic [7:0] op_byte, simd_pfx;
  logic [2:0] pfx_kind, mask_aaa;
  logic [3:0] vvvv;
  logic [4:0] vsrc, map_sel;
  logic [1:0] reg_hi, vlen;

  vecpfx_decoder u_dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, nv = 0;
  logic [7:0] q[$];
  logic [2:0] e_kind, e_aaa;
  logic e_r, e_x, e_b, e_r2, e_w, e_vp, e_z, e_bb, e_imm, e_fault;
  logic [3:0] e_vvvv;
  logic [4:0] e_map;
  logic [1:0] e_vlen, e_pp;
  logic [7:0] e_op;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      finish_run();
    end
  end

  function automatic logic [7:0] simd_of(input logic [1:0] p);
    case (p)
      2'b01: return 8'h66;
      2'b10: return 8'hF3;
      2'b11: return 8'hF2;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic is_pfx(input logic [7:0] b);
    return b inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h67, 8'hF0, 8'h66, 8'hF2, 8'hF3}
           || b[7:4] == 4'h4 || b inside {8'hC4, 8'hC5, 8'h62, 8'h8F};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic f);
    @(negedge clk);
    in_valid = 1'b1; in_first = f; in_byte = b;
    @(posedge clk); #1;
    in_valid = 1'b0; in_first = 1'b0;
    if (op_valid) nv++;
  endtask

  task automatic clear_exp();
    e_kind = 0; e_r = 0; e_x = 0; e_b = 0; e_r2 = 0; e_w = 0; e_vp = 0; e_z = 0; e_bb = 0;
    e_imm = 0; e_fault = 0; e_vvvv = 0; e_map = 0; e_vlen = 0; e_pp = 0; e_aaa = 0;
  endtask

  // kind: 0 none, 1 C5, 2 C4, 3 8F, 4 62
  task automatic run(input int npre, input logic [7:0] pa, input logic [7:0] pb, input int kind,
                     input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] op);
    logic bad;
    string tag;
    bad = 1'b0;
    q.delete();
    clear_exp();
    for (int i = 0; i < npre; i++) begin
      logic [7:0] pr;
      pr = (i == 0) ? pa : pb;
      q.push_back(pr);
      if (pr == 8'h66 || pr == 8'hF2 || pr == 8'hF3 || pr[7:4] == 4'h4) bad = 1'b1;
    end
    e_op = op;
    case (kind)
      0: begin tag = "R1"; q.push_back(op); end
      1: begin
        tag = "R2/R13";
        q.push_back(8'hC5); q.push_back(b1); q.push_back(op);
        e_kind = 1; e_r = ~b1[7]; e_vvvv = ~b1[6:3]; e_vlen = {1'b0, b1[2]}; e_pp = b1[1:0];
        e_map = 1; e_fault = bad;
      end
      2, 3: begin
        if (kind == 3 && b1[4:0] < 5'd8) begin
          tag = "R4";
          q.push_back(8'h8F); q.push_back(b1);
          e_op = 8'h8F;
        end else begin
          tag = (kind == 2) ? "R3/R13" : "R3/R9/R13";
          q.push_back(kind == 2 ? 8'hC4 : 8'h8F); q.push_back(b1); q.push_back(b2); q.push_back(op);
          e_kind = kind[2:0]; e_r = ~b1[7]; e_x = ~b1[6]; e_b = ~b1[5]; e_map = b1[4:0];
          e_w = b2[7]; e_vvvv = ~b2[6:3]; e_vlen = {1'b0, b2[2]}; e_pp = b2[1:0];
          if (kind == 2) e_fault = bad | !(e_map >= 1 && e_map <= 3);
          else begin
            e_fault = bad | !(e_map >= 8 && e_map <= 10);
            e_imm = (e_map == 8 || e_map == 10);
          end
        end
      end
      default: begin
        tag = "R5";
        q.push_back(8'h62); q.push_back(b1); q.push_back(b2); q.push_back(b3); q.push_back(op);
        e_kind = 4; e_r = ~b1[7]; e_x = ~b1[6]; e_b = ~b1[5]; e_r2 = ~b1[4]; e_map = {2'b00, b1[2:0]};
        e_w = b2[7]; e_vvvv = ~b2[6:3]; e_pp = b2[1:0];
        e_z = b3[7]; e_vlen = b3[6:5]; e_bb = b3[4]; e_vp = ~b3[3]; e_aaa = b3[2:0];
        e_fault = bad | (b1[2:0] == 3'd0) | (b1[2:0] == 3'd7) | (e_vlen == 2'b11 && !e_bb);
      end
    endcase
    nv = 0;
    foreach (q[i]) send(q[i], i == 0);
    check({"R1 one opcode pulse ", tag}, nv, 1);
    check({"R1 opcode byte ", tag}, op_byte, e_op);
    check("R6 complemented fields", {ext_r, ext_x, ext_b, ext_r2, vvvv}, {e_r, e_x, e_b, e_r2, e_vvvv});
    check("R7 implied prefix", simd_pfx, simd_of(e_pp));
    check("R8 five-bit indices", {reg_hi, vsrc}, {e_r2, e_r, e_vp, e_vvvv});
    check({tag, " format fields"}, {pfx_kind, w_bit, map_sel, vlen, mask_z, evex_b, mask_aaa, xop_imm},
          {e_kind, e_w, e_map, e_vlen, e_z, e_bb, e_aaa, e_imm});
    check("R10/R11 fault", ud_fault, e_fault);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C45));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", {op_valid, pfx_kind, ud_fault}, 0);
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    run(0, 0, 0, 1, 8'hFF, 0, 0, 8'h58);          // R2 all-ones payload -> zero fields
    run(0, 0, 0, 1, 8'h03, 0, 0, 8'h10);          // R6 all-zero payload -> all ones
    run(1, 8'h66, 0, 1, 8'hF9, 0, 0, 8'h77);      // R10 66h before short VEX
    run(1, 8'h48, 0, 2, 8'hE2, 8'h79, 0, 8'h18);  // R10 REX before long VEX
    run(2, 8'h67, 8'h2E, 2, 8'hE1, 8'h7D, 0, 8'h58); // legal prefixes, no fault
    run(0, 0, 0, 2, 8'hE4, 8'hFA, 0, 8'h01);      // R11 long VEX map 4
    run(0, 0, 0, 3, 8'hE8, 8'h78, 0, 8'hC0);      // R9 XOP map 8 with immediate
    run(0, 0, 0, 3, 8'hE9, 8'h78, 0, 8'h01);      // R9 XOP map 9
    run(0, 0, 0, 3, 8'hEA, 8'h78, 0, 8'h10);      // R9 XOP map A
    run(0, 0, 0, 3, 8'hEB, 8'h78, 0, 8'h10);      // R11 XOP map B
    run(0, 0, 0, 3, 8'h04, 0, 0, 0);              // R4 legacy 8Fh
    run(1, 8'hF3, 0, 3, 8'hC0, 0, 0, 0);          // R4 legacy 8Fh after F3h, no fault
    run(0, 0, 0, 4, 8'hF1, 8'h7C, 8'h68, 8'h58);  // R11 EVEX LL=11 b=0
    run(0, 0, 0, 4, 8'hF1, 8'h7C, 8'h78, 8'h58);  // R5 LL=11 as rounding, b=1
    run(0, 0, 0, 4, 8'h08, 8'h7D, 8'hC5, 8'h58);  // R11 EVEX map 0
    run(0, 0, 0, 4, 8'h0F, 8'h7D, 8'hC5, 8'h58);  // R11 EVEX map 7
    run(1, 8'hF2, 0, 4, 8'h62, 8'h7F, 8'h2A, 8'h6F); // R10 F2h before EVEX

    // R12 bytes after the opcode are ignored until in_first
    nv = 0;
    send(8'hC5, 1'b1); send(8'hF8, 1'b0); send(8'h58, 1'b0);
    nv = 0;
    send(8'hC0, 1'b0); send(8'h90, 1'b0); send(8'h62, 1'b0);
    check("R12 no output after opcode", nv, 0);
    check("R12 fields held", {pfx_kind, op_byte}, {3'd1, 8'h58});

    // R12 in_first restarts mid-prefix
    nv = 0;
    send(8'h62, 1'b1); send(8'hF1, 1'b0); send(8'h90, 1'b1);
    check("R12 restart opcode", {nv[7:0], op_byte, pfx_kind, ud_fault}, {8'd1, 8'h90, 3'd0, 1'b0});

    // constrained random
    for (int n = 0; n < 400; n++) begin
      int k, np;
      logic [7:0] pa, pb, b1, b2, b3, op;
      k = $urandom % 5;
      np = $urandom % 3;
      pa = ($urandom % 4 == 0) ? 8'h66 : 8'h2E;
      pb = ($urandom % 4 == 0) ? {4'h4, 4'($urandom)} : 8'h64;
      b1 = 8'($urandom); b2 = 8'($urandom); b3 = 8'($urandom);
      if (k == 3 && ($urandom % 4 != 0)) b1[4:0] = 5'd8 + 5'($urandom % 3);
      if (k == 2 && ($urandom % 4 != 0)) b1[4:0] = 5'd1 + 5'($urandom % 3);
      op = 8'($urandom);
      if (k == 0) while (is_pfx(op)) op = 8'($urandom);
      run(np, pa, pb, k, b1, b2, b3, op);
    end

    finish_run();
  end
endmodule